// File: doc/BRIEF.md
# External Interrupt Controller

This block collects eight external interrupt lines and turns them into a single request for the CPU. The request carries a vector number. Lines 0 to 3 are fixed: each one requests service for as long as its pin is held low. Lines 4 to 7 each take a two-bit sense code. The code picks low-level sensing, falling-edge capture or rising-edge capture. A captured edge is held in a flag until the CPU acknowledges that line or software clears the flag.

All pins pass through a two-stage synchroniser before any sensing happens. A per-line mask and one global enable decide whether a pending line may be presented. The lowest-numbered enabled line wins. Software reaches the mask, the sense codes, the flags and the global enable through a small register port. Accepting an interrupt drops the global enable. A return-from-interrupt pulse raises it again.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset the mask (address 0), sense codes (address 1), flags (address 2) and global enable (address 3, bit 0) all read zero, and `irq_valid_o` is low.
- R2: Lines 0 to 3 request while their pin is low. The request becomes visible two clock edges after the pin changes. It is not latched: it disappears two edges after the pin returns high.
- R3: Line 4+k uses sense bits [2k+1:2k] at address 1. Code 00 means low level, 10 means falling edge, 11 means rising edge, and 01 is reserved and never requests or sets a flag. An edge of the opposite direction sets no flag.
- R4: A qualifying edge on line 4+k sets flag bit 4+k at address 2 three clock edges after the pin changes. Bits 3:0 of address 2 always read zero.
- R5: Writing address 2 with a one in bit 4+k clears that flag. Zero bits in the written value leave flags unchanged.
- R6: An `ack_i` pulse while `irq_valid_o` is high clears the global enable and clears the flag of the presented line. Other flags are kept. A `reti_i` pulse sets the global enable.
- R7: While a line is in a non-edge mode its flag reads zero. A flag held at the moment the line leaves edge mode is discarded and does not come back when edge mode is restored.
- R8: A flag set while its mask bit or the global enable is zero stays pending. It is presented as soon as both become one.
- R9: Among enabled pending lines, the lowest index is presented, and `irq_vec_o` equals 2 + 2·n for line n.
- R10: `irq_valid_o` is high only when the global enable is one and at least one line is both pending and unmasked.
- R11: Addresses 0, 1 and 3 read back the value last written. Each write takes effect one clock edge later.
- R12: On an edge-mode line, a pulse that holds the pin at the active level across a single clock edge is captured in the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pin_i | input | 8 | Asynchronous external interrupt pins, idle high |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 mask, 1 sense, 2 flags, 3 control |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` (combinational) |
| ack_i | input | 1 | CPU accepts the presented interrupt |
| reti_i | input | 1 | Return from interrupt; sets the global enable |
| irq_valid_o | output | 1 | An enabled request is being presented |
| irq_vec_o | output | 8 | Vector number of the presented line |

## Verification
Each result has its own latency:
- A level request reaches `irq_valid_o` two edges after the pin moves.
- An edge flag appears on the flag read three edges after the pin moves.
- Register writes, `ack_i` and `reti_i` show their effect one edge later.
- Read data, valid and vector follow registered state within the same cycle.

The bench drives every input just after a rising edge. It then counts exactly that many edges before sampling. It also samples one edge early in the not-latched and latency cases, to show the result has not arrived too soon.

// File: rtl/xirq_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the external interrupt controller.
// Assumes the register port uses a 2-bit address.
package xirq_pkg;

    // Per-line sense code for the configurable lines.
    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_RSVD = 2'b01,
        SNS_FALL = 2'b10,
        SNS_RISE = 2'b11
    } sense_e;

    // Register addresses.
    localparam logic [1:0] ADDR_MASK  = 2'd0;
    localparam logic [1:0] ADDR_SENSE = 2'd1;
    localparam logic [1:0] ADDR_FLAG  = 2'd2;
    localparam logic [1:0] ADDR_CTRL  = 2'd3;

endpackage

// File: rtl/xirq_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for a bus of independent asynchronous pins.
// Assumes the pins idle high, so every stage resets to one.
// This way no request appears while the chain fills after reset.
module xirq_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift one sample per clock along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q[s] <= '1;
                end else if (s == 0) begin
                    chain_q[s] <= d_i;
                end else begin
                    chain_q[s] <= chain_q[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/xirq_line.sv
`timescale 1ns/1ps
// One configurable interrupt line. It senses a low level, a falling edge or a
// rising edge according to its sense code, and holds edge events in a flag.
// Assumes smp_i is already synchronised.
// In non-edge modes the flag is forced clear.
// A new edge wins over a clear request in the same cycle.
module xirq_line
    import xirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_i,
    input  logic [1:0] sense_i,
    input  logic       clr_i,
    output logic       req_o,
    output logic       flag_o
);

    sense_e mode;
    logic   prev_q;
    logic   flag_q;
    logic   edge_mode;
    logic   hit;

    assign mode = sense_e'(sense_i);

    // Remember the previous synchronised sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= smp_i;
    end

    // Decide whether this cycle carries a qualifying edge.
    always_comb begin
        edge_mode = (mode == SNS_FALL) || (mode == SNS_RISE);
        unique case (mode)
            SNS_FALL: hit = prev_q & ~smp_i;
            SNS_RISE: hit = ~prev_q & smp_i;
            default:  hit = 1'b0;
        endcase
    end

    // Edge flag: cleared outside edge mode, set by an edge, else cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (!edge_mode) flag_q <= 1'b0;
        else if (hit)        flag_q <= 1'b1;
        else if (clr_i)      flag_q <= 1'b0;
    end

    // Visible flag and request: level mode follows the pin, the reserved code stays idle.
    always_comb begin
        flag_o = flag_q & edge_mode;
        req_o  = (mode == SNS_LOW) ? ~smp_i : flag_o;
    end

endmodule

// File: rtl/xirq_prio.sv
`timescale 1ns/1ps
// Fixed-priority selector. The lowest index among the enabled requests wins.
// The result is presented as vector BASE + STEP * index.
// Assumes the largest vector fits in VEC_W bits.
module xirq_prio #(
    parameter int N     = 8,
    parameter int VEC_W = 8,
    parameter int BASE  = 2,
    parameter int STEP  = 2
) (
    input  logic [N-1:0]     req_i,
    input  logic             gie_i,
    output logic             valid_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [N-1:0]     grant_o
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [IDX_W-1:0] idx;
    logic             any;

    // Scan from the top down so that the lowest pending index is the last one kept.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx = IDX_W'(i);
        end
    end

    // Build the grant and the vector from the winning index.
    always_comb begin
        any      = |req_i;
        valid_o  = any & gie_i;
        grant_o  = '0;
        grant_o[idx] = any;
        vec_o    = valid_o ? VEC_W'(BASE + STEP * int'(idx)) : '0;
    end

endmodule

// File: rtl/xirq_ctrl.sv
`timescale 1ns/1ps
// External interrupt controller top.
// - Synchronises the pins.
// - Senses lines 0..N_FIXED-1 as fixed low level and the rest per sense code.
// - Masks the requests and presents the highest-priority one while the
//   global enable is set.
// Assumes DATA_W covers both N_LINES and 2*(N_LINES-N_FIXED).
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter int N_LINES     = 8,
    parameter int N_FIXED     = 4,
    parameter int DATA_W      = 8,
    parameter int VEC_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int VEC_BASE    = 2,
    parameter int VEC_STEP    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_pin_i,
    input  logic               reg_we_i,
    input  logic [1:0]         reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    input  logic               ack_i,
    input  logic               reti_i,
    output logic               irq_valid_o,
    output logic [VEC_W-1:0]   irq_vec_o
);

    localparam int N_CFG = N_LINES - N_FIXED;
    localparam int SNS_W = 2 * N_CFG;

    logic [N_LINES-1:0] mask_q;
    logic [SNS_W-1:0]   sense_q;
    logic               gie_q;
    logic [N_LINES-1:0] pin_s;
    logic [N_LINES-1:0] req;
    logic [N_LINES-1:0] grant;
    logic [N_CFG-1:0]   flag_vis;
    logic [N_LINES-1:0] flag_view;
    logic               ack_take;
    logic               wr_mask;
    logic               wr_sense;
    logic               wr_flag;
    logic               wr_ctrl;

    // Decode the register write strobes.
    always_comb begin
        wr_mask  = reg_we_i && (reg_addr_i == ADDR_MASK);
        wr_sense = reg_we_i && (reg_addr_i == ADDR_SENSE);
        wr_flag  = reg_we_i && (reg_addr_i == ADDR_FLAG);
        wr_ctrl  = reg_we_i && (reg_addr_i == ADDR_CTRL);
        ack_take = ack_i && irq_valid_o;
    end

    // Mask and sense-code registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            sense_q <= '0;
        end else begin
            if (wr_mask)  mask_q  <= reg_wdata_i[N_LINES-1:0];
            if (wr_sense) sense_q <= reg_wdata_i[SNS_W-1:0];
        end
    end

    // Global enable: acknowledge clears it, then return sets it, then a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)        gie_q <= 1'b0;
        else if (ack_take) gie_q <= 1'b0;
        else if (reti_i)   gie_q <= 1'b1;
        else if (wr_ctrl)  gie_q <= reg_wdata_i[0];
    end

    xirq_sync #(
        .W      (N_LINES),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (irq_pin_i),
        .q_o   (pin_s)
    );

    generate
        for (genvar f = 0; f < N_FIXED; f++) begin : g_fixed
            assign req[f] = ~pin_s[f];
        end
        for (genvar k = 0; k < N_CFG; k++) begin : g_cfg
            logic clr;
            assign clr = (wr_flag && reg_wdata_i[N_FIXED+k]) ||
                         (ack_take && grant[N_FIXED+k]);
            xirq_line line_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .smp_i   (pin_s[N_FIXED+k]),
                .sense_i (sense_q[2*k+1:2*k]),
                .clr_i   (clr),
                .req_o   (req[N_FIXED+k]),
                .flag_o  (flag_vis[k])
            );
        end
    endgenerate

    xirq_prio #(
        .N     (N_LINES),
        .VEC_W (VEC_W),
        .BASE  (VEC_BASE),
        .STEP  (VEC_STEP)
    ) prio_i (
        .req_i   (req & mask_q),
        .gie_i   (gie_q),
        .valid_o (irq_valid_o),
        .vec_o   (irq_vec_o),
        .grant_o (grant)
    );

    // Register read mux; the fixed lines contribute zero flag bits.
    always_comb begin
        flag_view = {flag_vis, {N_FIXED{1'b0}}};
        unique case (reg_addr_i)
            ADDR_MASK:  reg_rdata_o = DATA_W'(mask_q);
            ADDR_SENSE: reg_rdata_o = DATA_W'(sense_q);
            ADDR_FLAG:  reg_rdata_o = DATA_W'(flag_view);
            default:    reg_rdata_o = DATA_W'(gie_q);
        endcase
    end

endmodule

// File: rtl/xirq_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for xirq_ctrl. It is attached to the top through the bind below.
// It relies only on ports and on the global-enable register.
module xirq_ctrl_chk #(
    parameter int N_LINES  = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 2,
    parameter int VEC_STEP = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack_i,
    input logic             reti_i,
    input logic             irq_valid_o,
    input logic [VEC_W-1:0] irq_vec_o,
    input logic             gie_i
);

    localparam int VEC_MAX = VEC_BASE + VEC_STEP * (N_LINES - 1);

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!irq_valid_o && !gie_i)); // R1

    AST_VALID_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> gie_i); // R10

    AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> (int'(irq_vec_o) >= VEC_BASE && int'(irq_vec_o) <= VEC_MAX &&
                         ((int'(irq_vec_o) - VEC_BASE) % VEC_STEP) == 0)); // R9

    AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_valid_o) |=> !gie_i); // R6

    AST_RETI_RAISES_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !(ack_i && irq_valid_o)) |=> gie_i); // R6

endmodule

bind xirq_ctrl xirq_ctrl_chk #(
    .N_LINES  (N_LINES),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (ack_i),
    .reti_i      (reti_i),
    .irq_valid_o (irq_valid_o),
    .irq_vec_o   (irq_vec_o),
    .gie_i       (gie_q)
);

// File: tb/xirq_ctrl_tb.sv
`timescale 1ns/100ps
// Self-checking bench for xirq_ctrl.
// A vector table covers level sensing, masking and priority.
// Directed tests then cover reset, edges, flags, acknowledge and return.
module xirq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pins = 8'hFF;
    logic       we = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       ack = 1'b0;
    logic       reti = 1'b0;
    logic       valid;
    logic [7:0] vec;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xirq_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_pin_i   (pins),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .ack_i       (ack),
        .reti_i      (reti),
        .irq_valid_o (valid),
        .irq_vec_o   (vec)
    );

    // Entries: {pins[7:0], mask[7:0], exp_valid, exp_vec[7:0]}, all lines in level mode.
    localparam logic [24:0] TBL [10] = '{
        {8'hFF, 8'hFF, 1'b0, 8'd0},
        {8'hFE, 8'hFF, 1'b1, 8'd2},
        {8'hF0, 8'hFF, 1'b1, 8'd2},
        {8'hF0, 8'hFE, 1'b1, 8'd4},
        {8'hF3, 8'hFF, 1'b1, 8'd6},
        {8'h7F, 8'hFF, 1'b1, 8'd16},
        {8'h7F, 8'h7F, 1'b0, 8'd0},
        {8'h00, 8'h00, 1'b0, 8'd0},
        {8'h00, 8'h80, 1'b1, 8'd16},
        {8'hEF, 8'hFF, 1'b1, 8'd10}
    };

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        we = 1'b1; addr = a; wdata = d;
        step(1);
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        addr = a;
        #0.1;
        chk(tag, 32'(rdata), 32'(exp));
    endtask

    task automatic pulse_ack();
        ack = 1'b1; step(1); ack = 1'b0;
    endtask

    task automatic pulse_reti();
        reti = 1'b1; step(1); reti = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        rd(2'd0, 8'h00, "R1 mask");
        rd(2'd1, 8'h00, "R1 sense");
        rd(2'd2, 8'h00, "R1 flags");
        rd(2'd3, 8'h00, "R1 gie");
        chk("R1 valid", 32'(valid), 32'd0);

        // R11: read-back of written registers
        wr(2'd1, 8'hE4);
        rd(2'd1, 8'hE4, "R11 sense readback");
        wr(2'd1, 8'h00);
        wr(2'd3, 8'h01);
        rd(2'd3, 8'h01, "R11 gie readback");

        // R2 R9 R10: level table
        for (int i = 0; i < 10; i++) begin
            wr(2'd0, TBL[i][16:9]);
            rd(2'd0, TBL[i][16:9], "R11 mask readback");
            pins = TBL[i][24:17];
            step(2);
            chk($sformatf("R9 R10 valid entry %0d", i), 32'(valid), 32'(TBL[i][8]));
            chk($sformatf("R9 vec entry %0d", i), 32'(vec), 32'(TBL[i][7:0]));
        end
        pins = 8'hFF;
        step(2);

        // R2: not latched, two-edge latency
        wr(2'd0, 8'h01);
        pins[0] = 1'b0;
        step(1);
        chk("R2 not yet valid", 32'(valid), 32'd0);
        step(1);
        chk("R2 valid after two edges", 32'(valid), 32'd1);
        pins[0] = 1'b1;
        step(1);
        chk("R2 still valid one edge after release", 32'(valid), 32'd1);
        step(1);
        chk("R2 released", 32'(valid), 32'd0);

        // R4 R3: falling edge on line 4 (code 10 in bits 1:0)
        wr(2'd1, 8'h02);
        wr(2'd0, 8'h10);
        wr(2'd3, 8'h00);
        pins[4] = 1'b0;
        step(2);
        rd(2'd2, 8'h00, "R4 flag not before third edge");
        step(1);
        rd(2'd2, 8'h10, "R4 R3 falling flag");
        chk("R10 gie off no valid", 32'(valid), 32'd0);

        // R8: pending across mask and enable
        wr(2'd0, 8'h00);
        wr(2'd3, 8'h01);
        chk("R8 masked no valid", 32'(valid), 32'd0);
        rd(2'd2, 8'h10, "R8 flag held");
        wr(2'd0, 8'h10);
        chk("R8 presented valid", 32'(valid), 32'd1);
        chk("R8 presented vec", 32'(vec), 32'd10);

        // R6: acknowledge and return
        pulse_ack();
        rd(2'd2, 8'h00, "R6 ack clears flag");
        rd(2'd3, 8'h00, "R6 ack clears gie");
        chk("R6 valid after ack", 32'(valid), 32'd0);
        pulse_reti();
        rd(2'd3, 8'h01, "R6 reti sets gie");
        pins[4] = 1'b1;
        step(3);
        rd(2'd2, 8'h00, "R3 rising ignored in falling mode");

        // R5 R3: rising edge on line 5 (code 11 in bits 3:2)
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h0E);
        pins[5] = 1'b0;
        step(3);
        rd(2'd2, 8'h00, "R3 falling ignored in rising mode");
        pins[5] = 1'b1;
        step(3);
        rd(2'd2, 8'h20, "R3 rising flag");
        wr(2'd2, 8'h00);
        rd(2'd2, 8'h20, "R5 zero write keeps flag");
        wr(2'd2, 8'h10);
        rd(2'd2, 8'h20, "R5 other bit keeps flag");
        wr(2'd2, 8'h20);
        rd(2'd2, 8'h00, "R5 one clears flag");

        // R3: reserved code 01 on line 6 (bits 5:4)
        wr(2'd1, 8'h1E);
        wr(2'd0, 8'h40);
        pins[6] = 1'b0;
        step(3);
        chk("R3 reserved no request", 32'(valid), 32'd0);
        rd(2'd2, 8'h00, "R3 reserved no flag");
        pins[6] = 1'b1;
        step(3);

        // R7: flag discarded when line 7 leaves edge mode (bits 7:6)
        wr(2'd1, 8'hDE);
        pins[7] = 1'b0;
        step(3);
        pins[7] = 1'b1;
        step(3);
        rd(2'd2, 8'h80, "R7 flag set in rising mode");
        wr(2'd1, 8'h1E);
        rd(2'd2, 8'h00, "R7 level mode reads zero");
        wr(2'd1, 8'hDE);
        rd(2'd2, 8'h00, "R7 flag not restored");

        // R12: one-cycle low pulse on line 6 in falling mode
        wr(2'd1, 8'hEE);
        wr(2'd0, 8'h00);
        pins[6] = 1'b0;
        step(1);
        pins[6] = 1'b1;
        step(3);
        rd(2'd2, 8'h40, "R12 short pulse captured");

        // R9 R6: two flags, acknowledge removes only the presented one
        pins[4] = 1'b0;
        step(3);
        rd(2'd2, 8'h50, "R9 two flags");
        wr(2'd0, 8'h50);
        chk("R9 line 4 first", 32'(vec), 32'd10);
        pulse_ack();
        rd(2'd2, 8'h40, "R6 other flag kept");
        chk("R6 no valid after ack", 32'(valid), 32'd0);
        pulse_reti();
        chk("R9 line 6 next valid", 32'(valid), 32'd1);
        chk("R9 line 6 next vec", 32'(vec), 32'd14);
        wr(2'd0, 8'h54);
        pins[2] = 1'b0;
        step(2);
        chk("R9 level line 2 beats flags", 32'(vec), 32'd6);
        pulse_ack();
        rd(2'd2, 8'h40, "R6 level ack leaves flags");
        pins = 8'hFF;
        step(3);

        finish_run();
    end

endmodule